// File: doc/BRIEF.md
# PCI Type-0 Configuration Register File

This block holds the configuration header of a PCI target function: the identity words, the Command and Status pair, a bank of base address registers, the header bytes that software programs, and a power-management capability. A host-side sequencer presents one dword index at a time, together with write data and four byte enables, and raises either a read strobe or a write strobe. Read data is captured into an output register on the clock edge that sees the read strobe, and it holds until the next read.

The function reports four conditions into the block: a detected parity error, an assertion of the system-error line, a transaction ended with target-abort, and its own interrupt request. The first three are latched into Status bits that software clears by writing ones. The interrupt request appears live in Status and drives an active-low legacy interrupt output. The Command register can mask that output without changing the Status bit.

Top module: `pci_cfg_space`

## Requirements
- R1: After reset, rd_data is 0, inta_n is 1, and a read of index 1 (byte offset 04h) returns 0x02100000 while irq_req is 0.
- R2: Index 0 returns {DEV_ID, VEN_ID}, index 2 returns {CLASS_CODE, REV_ID}, and index 11 returns {SUBSYS_ID, SUBSYS_VEN}. Writes to these indices change nothing.
- R3: Command (index 1, bits 15:0) implements bits 1, 6, 8 and 10 as read/write with reset value 0. Byte enable 0 covers bits 7:0 and byte enable 1 covers bits 15:8. All other Command bits read 0.
- R4: A one-cycle pulse on evt_parity, evt_serr or evt_tabort sets Status bit 15, 14 or 11 respectively (read data bits 31, 30, 27). A parity pulse sets bit 15 even while Command bit 6 is 0.
- R5: A write to index 1 with byte enable 3 set clears each of Status bits 15, 14 and 11 whose data bit (31, 30, 27) is 1. A data bit of 0, or byte enable 3 clear, leaves the bit unchanged.
- R6: When an event pulse and a write-one clear of the same Status bit fall in the same cycle, the bit stays set.
- R7: Status bits 10:9 always read 01b and bit 4 always reads 1. All Status bits other than 15, 14 and 11 ignore writes.
- R8: Status bit 3 (read data bit 19) equals irq_req at the read edge, whatever the value of Command bit 10.
- R9: On each clock edge inta_n is loaded with 0 when irq_req is 1 and Command bit 10 is 0, and with 1 otherwise.
- R10: BAR n sits at index 4+n for each n where BAR_USED[n] is 1. Bits 31:BAR_SIZE_LOG2 are read/write under their byte enables, and the lower bits read 0.
- R11: Index 13 returns 0x00000040. Index 16 returns {PM_CAPS, 8'h00 next pointer, 8'h00 capability ID}. Index 17 keeps bits 1:0 as read/write power state and reads 0 in all other bits.
- R12: Indices with no register return 0 and ignore writes. These are 10, 12, 14, 18 to 63, and BAR indices whose BAR_USED bit is 0.
- R13: rd_data changes only on an edge where rd_stb is 1, and then takes the value of the addressed register before that edge's writes and events.
- R14: Index 3 keeps bits 7:0 and 15:8 read/write and reads 0 in bits 31:16. Index 15 keeps bits 7:0 read/write and returns {MAX_LAT, MIN_GNT, INT_PIN} in bits 31:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dw | input | 6 | Dword index of the register (byte offset / 4) |
| wr_data | input | 32 | Write data |
| byte_en | input | 4 | Byte enables for writes, bit n covers data bits 8n+7:8n |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| rd_data | output | 32 | Registered read data |
| evt_parity | input | 1 | Parity error detected |
| evt_serr | input | 1 | System-error line asserted by the function |
| evt_tabort | input | 1 | Transaction ended with target-abort |
| irq_req | input | 1 | Interrupt request of the function |
| inta_n | output | 1 | Active-low legacy interrupt |

## Verification
The hardest case to reach from the ports is an event pulse that lands on the same edge as a write that clears that same Status bit. The stimulus raises evt_parity and the write strobe together on a single falling edge, with data bit 31 and byte enable 3 set, and then reads Status to confirm that the bit survived. A second hard case is a write carrying a clear bit while byte enable 3 is off. It is reached by a write whose lower byte enables leave Command unchanged.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

  localparam int DW_W = 6;

  localparam logic [DW_W-1:0] IDX_IDENT   = 6'd0;
  localparam logic [DW_W-1:0] IDX_CMDSTAT = 6'd1;
  localparam logic [DW_W-1:0] IDX_CLASS   = 6'd2;
  localparam logic [DW_W-1:0] IDX_HDRB    = 6'd3;
  localparam logic [DW_W-1:0] IDX_BAR0    = 6'd4;
  localparam logic [DW_W-1:0] IDX_SUBSYS  = 6'd11;
  localparam logic [DW_W-1:0] IDX_CAPPTR  = 6'd13;
  localparam logic [DW_W-1:0] IDX_INTR    = 6'd15;
  localparam logic [DW_W-1:0] IDX_PMCAP   = 6'd16;
  localparam logic [DW_W-1:0] IDX_PMCSR   = 6'd17;
  localparam logic [DW_W-1:0] IDX_LAST    = 6'd17;

  localparam logic [15:0] CMD_RW_MASK = 16'h0542;
  localparam int          CMD_INTDIS  = 10;
  localparam logic [7:0]  CAP_BASE    = 8'h40;

  typedef logic [2:0] sticky_t;
  localparam int STK_PAR  = 2;
  localparam int STK_SERR = 1;
  localparam int STK_TAB  = 0;

endpackage

// File: rtl/pci_cfg_cmdstat.sv
module pci_cfg_cmdstat
  import pci_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [1:0]  cmd_be,
  input  logic [15:0] cmd_wdata,
  input  logic        clr_be,
  input  sticky_t     clr_bits,
  input  sticky_t     evt,
  input  logic        irq_req,
  output logic [15:0] cmd_q,
  output logic [15:0] stat_word,
  output logic        inta_n
);

  logic [15:0] cmd_d;
  logic [15:0] cmd_mask;
  sticky_t     stk_q;
  sticky_t     stk_d;
  sticky_t     clr_now;
  logic        inta_d;

  always_comb begin
    cmd_mask = {{8{cmd_be[1]}}, {8{cmd_be[0]}}} & CMD_RW_MASK;
    cmd_d    = cmd_q;
    if (wr_hit) begin
      cmd_d = (cmd_q & ~cmd_mask) | (cmd_wdata & cmd_mask);
    end
  end

  always_comb begin
    clr_now = (wr_hit && clr_be) ? clr_bits : '0;
    stk_d   = (stk_q & ~clr_now) | evt;
  end

  always_comb begin
    inta_d = ~(irq_req & ~cmd_q[CMD_INTDIS]);
  end

  always_comb begin
    stat_word = {stk_q[STK_PAR], stk_q[STK_SERR], 2'b00, stk_q[STK_TAB],
                 2'b01, 4'b0000, 1'b1, irq_req, 3'b000};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      stk_q  <= '0;
      inta_n <= 1'b1;
    end else begin
      cmd_q  <= cmd_d;
      stk_q  <= stk_d;
      inta_n <= inta_d;
    end
  end

  p_parity_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt[STK_PAR] |=> stk_q[STK_PAR]);
  p_serr_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt[STK_SERR] |=> stk_q[STK_SERR]);
  p_tabort_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt[STK_TAB] |=> stk_q[STK_TAB]);
  p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && clr_be && clr_bits[STK_SERR] && !evt[STK_SERR]) |=> !stk_q[STK_SERR]);
  p_sticky_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_q[STK_PAR] && !(wr_hit && clr_be && clr_bits[STK_PAR])) |=> stk_q[STK_PAR]);
  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[STK_TAB] && wr_hit && clr_be && clr_bits[STK_TAB]) |=> stk_q[STK_TAB]);
  p_inta_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[CMD_INTDIS] |=> inta_n);
  p_inta_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |=> inta_n);
  p_inta_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !cmd_q[CMD_INTDIS]) |=> !inta_n);

endmodule

// File: rtl/pci_cfg_hdrbytes.sv
module pci_cfg_hdrbytes (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hdr,
  input  logic [1:0]  hdr_be,
  input  logic [15:0] hdr_wdata,
  input  logic        wr_intl,
  input  logic [7:0]  intl_wdata,
  input  logic        wr_pm,
  input  logic [1:0]  pm_wdata,
  output logic [7:0]  cls_q,
  output logic [7:0]  lat_q,
  output logic [7:0]  intl_q,
  output logic [1:0]  pm_q
);

  logic [7:0] cls_d;
  logic [7:0] lat_d;
  logic [7:0] intl_d;
  logic [1:0] pm_d;

  always_comb begin
    cls_d  = (wr_hdr && hdr_be[0]) ? hdr_wdata[7:0]  : cls_q;
    lat_d  = (wr_hdr && hdr_be[1]) ? hdr_wdata[15:8] : lat_q;
    intl_d = wr_intl ? intl_wdata : intl_q;
    pm_d   = wr_pm   ? pm_wdata   : pm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q  <= '0;
      lat_q  <= '0;
      intl_q <= '0;
      pm_q   <= '0;
    end else begin
      cls_q  <= cls_d;
      lat_q  <= lat_d;
      intl_q <= intl_d;
      pm_q   <= pm_d;
    end
  end

  p_pm_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pm |=> $stable(pm_q));
  p_intl_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_intl |=> $stable(intl_q));

endmodule

// File: rtl/pci_cfg_bar.sv
module pci_cfg_bar #(
  parameter int SIZE_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] bar_q
);

  localparam logic [31:0] ADDR_MASK = ~((32'd1 << SIZE_LOG2) - 32'd1);

  logic [31:0] be_mask;
  logic [31:0] bar_d;

  always_comb begin
    be_mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}} & ADDR_MASK;
    bar_d   = bar_q;
    if (wr_hit) begin
      bar_d = (bar_q & ~be_mask) | (wdata & be_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bar_q <= '0;
    end else begin
      bar_q <= bar_d;
    end
  end

  p_bar_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(bar_q));

endmodule

// File: rtl/pci_cfg_space.sv
module pci_cfg_space
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID        = 16'hC0DE,
  parameter logic [15:0] VEN_ID        = 16'h1BAD,
  parameter logic [7:0]  REV_ID        = 8'h03,
  parameter logic [23:0] CLASS_CODE    = 24'h070002,
  parameter logic [15:0] SUBSYS_ID     = 16'h0958,
  parameter logic [15:0] SUBSYS_VEN    = 16'h1BAD,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [7:0]  MIN_GNT       = 8'h00,
  parameter logic [7:0]  MAX_LAT       = 8'h00,
  parameter logic [15:0] PM_CAPS       = 16'h0003,
  parameter int          NUM_BARS      = 6,
  parameter logic [5:0]  BAR_USED      = 6'b000111,
  parameter int          BAR_SIZE_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  cfg_dw,
  input  logic [31:0] wr_data,
  input  logic [3:0]  byte_en,
  input  logic        rd_stb,
  input  logic        wr_stb,
  output logic [31:0] rd_data,
  input  logic        evt_parity,
  input  logic        evt_serr,
  input  logic        evt_tabort,
  input  logic        irq_req,
  output logic        inta_n
);

  logic [15:0] cmd_q;
  logic [15:0] stat_word;
  logic [7:0]  cls_q;
  logic [7:0]  lat_q;
  logic [7:0]  intl_q;
  logic [1:0]  pm_q;
  logic [31:0] bar_rd [NUM_BARS];
  logic [31:0] rd_mux;
  logic [31:0] rd_d;
  sticky_t     evt_vec;
  sticky_t     clr_vec;

  always_comb begin
    evt_vec           = '0;
    evt_vec[STK_PAR]  = evt_parity;
    evt_vec[STK_SERR] = evt_serr;
    evt_vec[STK_TAB]  = evt_tabort;
    clr_vec           = '0;
    clr_vec[STK_PAR]  = wr_data[31];
    clr_vec[STK_SERR] = wr_data[30];
    clr_vec[STK_TAB]  = wr_data[27];
  end

  pci_cfg_cmdstat u_cmdstat (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_stb && (cfg_dw == IDX_CMDSTAT)),
    .cmd_be    (byte_en[1:0]),
    .cmd_wdata (wr_data[15:0]),
    .clr_be    (byte_en[3]),
    .clr_bits  (clr_vec),
    .evt       (evt_vec),
    .irq_req   (irq_req),
    .cmd_q     (cmd_q),
    .stat_word (stat_word),
    .inta_n    (inta_n)
  );

  pci_cfg_hdrbytes u_hdrbytes (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hdr     (wr_stb && (cfg_dw == IDX_HDRB)),
    .hdr_be     (byte_en[1:0]),
    .hdr_wdata  (wr_data[15:0]),
    .wr_intl    (wr_stb && byte_en[0] && (cfg_dw == IDX_INTR)),
    .intl_wdata (wr_data[7:0]),
    .wr_pm      (wr_stb && byte_en[0] && (cfg_dw == IDX_PMCSR)),
    .pm_wdata   (wr_data[1:0]),
    .cls_q      (cls_q),
    .lat_q      (lat_q),
    .intl_q     (intl_q),
    .pm_q       (pm_q)
  );

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
    if (BAR_USED[g]) begin : g_impl
      pci_cfg_bar #(
        .SIZE_LOG2 (BAR_SIZE_LOG2)
      ) u_bar (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_stb && (cfg_dw == IDX_BAR0 + 6'(g))),
        .be     (byte_en),
        .wdata  (wr_data),
        .bar_q  (bar_rd[g])
      );
    end else begin : g_none
      assign bar_rd[g] = '0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (cfg_dw)
      IDX_IDENT:   rd_mux = {DEV_ID, VEN_ID};
      IDX_CMDSTAT: rd_mux = {stat_word, cmd_q};
      IDX_CLASS:   rd_mux = {CLASS_CODE, REV_ID};
      IDX_HDRB:    rd_mux = {16'h0000, lat_q, cls_q};
      IDX_SUBSYS:  rd_mux = {SUBSYS_ID, SUBSYS_VEN};
      IDX_CAPPTR:  rd_mux = {24'h000000, CAP_BASE};
      IDX_INTR:    rd_mux = {MAX_LAT, MIN_GNT, INT_PIN, intl_q};
      IDX_PMCAP:   rd_mux = {PM_CAPS, 8'h00, 8'h00};
      IDX_PMCSR:   rd_mux = {30'd0, pm_q};
      default:     rd_mux = '0;
    endcase
    for (int i = 0; i < NUM_BARS; i++) begin
      if (cfg_dw == IDX_BAR0 + 6'(i)) begin
        rd_mux = bar_rd[i];
      end
    end
  end

  always_comb begin
    rd_d = rd_stb ? rd_mux : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else begin
      rd_data <= rd_d;
    end
  end

  p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
  p_unimpl_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (cfg_dw > IDX_LAST)) |=> (rd_data == 32'd0));
  p_ident_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (cfg_dw == IDX_IDENT)) |=> (rd_data == {DEV_ID, VEN_ID}));

endmodule

// File: tb/pci_cfg_space_tb.sv
module pci_cfg_space_tb;

  localparam logic [15:0] T_DEV   = 16'hC0DE;
  localparam logic [15:0] T_VEN   = 16'h1BAD;
  localparam logic [7:0]  T_REV   = 8'h03;
  localparam logic [23:0] T_CLASS = 24'h070002;
  localparam logic [15:0] T_SSID  = 16'h0958;
  localparam logic [15:0] T_SSVEN = 16'h1BAD;
  localparam logic [7:0]  T_PIN   = 8'h01;
  localparam logic [7:0]  T_MING  = 8'h00;
  localparam logic [7:0]  T_MAXL  = 8'h00;
  localparam logic [15:0] T_PMC   = 16'h0003;
  localparam logic [5:0]  T_USED  = 6'b000111;
  localparam int          T_SLOG  = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  byte_en = '0;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [31:0] rd_data;
  logic        evt_parity = 1'b0;
  logic        evt_serr = 1'b0;
  logic        evt_tabort = 1'b0;
  logic        irq_req = 1'b0;
  logic        inta_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pci_cfg_space #(
    .DEV_ID(T_DEV), .VEN_ID(T_VEN), .REV_ID(T_REV), .CLASS_CODE(T_CLASS),
    .SUBSYS_ID(T_SSID), .SUBSYS_VEN(T_SSVEN), .INT_PIN(T_PIN),
    .MIN_GNT(T_MING), .MAX_LAT(T_MAXL), .PM_CAPS(T_PMC),
    .NUM_BARS(6), .BAR_USED(T_USED), .BAR_SIZE_LOG2(T_SLOG)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_dw(cfg_dw), .wr_data(wr_data),
    .byte_en(byte_en), .rd_stb(rd_stb), .wr_stb(wr_stb), .rd_data(rd_data),
    .evt_parity(evt_parity), .evt_serr(evt_serr), .evt_tabort(evt_tabort),
    .irq_req(irq_req), .inta_n(inta_n)
  );

  // Behavioural reference model
  logic [15:0] m_cmd = '0;
  bit          m_par = 0, m_serr = 0, m_tab = 0;
  logic [31:0] m_bar [6];
  logic [7:0]  m_cls = '0, m_lat = '0, m_intl = '0;
  logic [1:0]  m_pm = '0;
  logic [31:0] m_rd = '0;
  bit          m_inta = 1'b1;

  function automatic logic [31:0] mread(input logic [5:0] dw);
    logic [15:0] st;
    st = 16'h0210;
    if (m_par)   st[15] = 1'b1;
    if (m_serr)  st[14] = 1'b1;
    if (m_tab)   st[11] = 1'b1;
    if (irq_req) st[3]  = 1'b1;
    case (dw)
      6'd0:  return {T_DEV, T_VEN};
      6'd1:  return {st, m_cmd};
      6'd2:  return {T_CLASS, T_REV};
      6'd3:  return {16'h0, m_lat, m_cls};
      6'd11: return {T_SSID, T_SSVEN};
      6'd13: return 32'h40;
      6'd15: return {T_MAXL, T_MING, T_PIN, m_intl};
      6'd16: return {T_PMC, 16'h0};
      6'd17: return {30'd0, m_pm};
      default: begin
        if (dw >= 6'd4 && dw <= 6'd9 && T_USED[dw - 6'd4]) return m_bar[dw - 6'd4];
        return 32'd0;
      end
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] nrd;
    bit          ninta;
    if (!rst_n) begin
      m_cmd = '0; m_par = 0; m_serr = 0; m_tab = 0;
      for (int i = 0; i < 6; i++) m_bar[i] = '0;
      m_cls = '0; m_lat = '0; m_intl = '0; m_pm = '0;
      m_rd = '0; m_inta = 1'b1;
    end else begin
      nrd   = rd_stb ? mread(cfg_dw) : m_rd;
      ninta = !(irq_req && !m_cmd[10]);
      if (wr_stb) begin
        if (cfg_dw == 6'd1) begin
          for (int b = 0; b < 16; b++)
            if (byte_en[b/8] && (b == 1 || b == 6 || b == 8 || b == 10)) m_cmd[b] = wr_data[b];
          if (byte_en[3]) begin
            if (wr_data[31]) m_par = 0;
            if (wr_data[30]) m_serr = 0;
            if (wr_data[27]) m_tab = 0;
          end
        end else if (cfg_dw == 6'd3) begin
          if (byte_en[0]) m_cls = wr_data[7:0];
          if (byte_en[1]) m_lat = wr_data[15:8];
        end else if (cfg_dw >= 6'd4 && cfg_dw <= 6'd9) begin
          for (int b = T_SLOG; b < 32; b++)
            if (byte_en[b/8]) m_bar[cfg_dw - 6'd4][b] = wr_data[b];
        end else if (cfg_dw == 6'd15 && byte_en[0]) begin
          m_intl = wr_data[7:0];
        end else if (cfg_dw == 6'd17 && byte_en[0]) begin
          m_pm = wr_data[1:0];
        end
      end
      if (evt_parity) m_par = 1;
      if (evt_serr)   m_serr = 1;
      if (evt_tabort) m_tab = 1;
      m_rd   = nrd;
      m_inta = ninta;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model, mid high phase
  always @(posedge clk) begin
    #5;
    if (!done) begin
      chk("R13 model rd_data", rd_data, m_rd);
      chk("R9 model inta_n", {31'd0, inta_n}, {31'd0, m_inta});
    end
  end

  task automatic wr(input logic [5:0] dw, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_dw = dw; wr_data = d; byte_en = be; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; byte_en = '0;
  endtask

  task automatic rd(input logic [5:0] dw, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_dw = dw; rd_stb = 1'b1;
    @(posedge clk);
    #5;
    chk(tag, rd_data, exp);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic set_irq(input bit v, input bit exp_n, input string tag);
    @(negedge clk);
    irq_req = v;
    @(posedge clk);
    #5;
    chk(tag, {31'd0, inta_n}, {31'd0, exp_n});
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_data reset", rd_data, 32'h0);
    chk("R1 inta_n reset", {31'd0, inta_n}, 32'd1);
    rd(6'd1, 32'h0210_0000, "R1 cmd/status after reset");

    // R2 identity, read only
    rd(6'd0, {T_DEV, T_VEN}, "R2 ident");
    wr(6'd0, 32'hFFFF_FFFF, 4'hF);
    rd(6'd0, {T_DEV, T_VEN}, "R2 ident after write");
    wr(6'd2, 32'h0, 4'hF);
    rd(6'd2, {T_CLASS, T_REV}, "R2 class");
    rd(6'd11, {T_SSID, T_SSVEN}, "R2 subsystem");

    // R3 command bits
    wr(6'd1, 32'h0000_FFFF, 4'b0011);
    rd(6'd1, 32'h0210_0542, "R3 cmd all set");
    wr(6'd1, 32'h0, 4'b0001);
    rd(6'd1, 32'h0210_0500, "R3 cmd low byte");
    wr(6'd1, 32'h0, 4'b0010);
    rd(6'd1, 32'h0210_0000, "R3 cmd high byte");

    // R4 sticky events, parity with response disabled
    @(negedge clk); evt_parity = 1'b1; @(negedge clk); evt_parity = 1'b0;
    rd(6'd1, 32'h8210_0000, "R4 parity");
    @(negedge clk); evt_serr = 1'b1; @(negedge clk); evt_serr = 1'b0;
    rd(6'd1, 32'hC210_0000, "R4 serr");
    @(negedge clk); evt_tabort = 1'b1; @(negedge clk); evt_tabort = 1'b0;
    rd(6'd1, 32'hCA10_0000, "R4 tabort");

    // R5 write one to clear
    wr(6'd1, 32'h0, 4'b1000);
    rd(6'd1, 32'hCA10_0000, "R5 zero write");
    wr(6'd1, 32'h8000_0000, 4'b0111);
    rd(6'd1, 32'hCA10_0000, "R5 byte enable off");
    wr(6'd1, 32'h8000_0000, 4'b1000);
    rd(6'd1, 32'h4A10_0000, "R5 clear parity");
    wr(6'd1, 32'h4800_0000, 4'b1000);
    rd(6'd1, 32'h0210_0000, "R5 clear rest");

    // R6 event wins over clear
    @(negedge clk);
    evt_parity = 1'b1; cfg_dw = 6'd1; wr_data = 32'h8000_0000; byte_en = 4'b1000; wr_stb = 1'b1;
    @(negedge clk);
    evt_parity = 1'b0; wr_stb = 1'b0; byte_en = '0;
    rd(6'd1, 32'h8210_0000, "R6 event wins");
    wr(6'd1, 32'h8000_0000, 4'b1000);

    // R7 fixed bits ignore writes
    wr(6'd1, 32'h36EF_0000, 4'b1100);
    rd(6'd1, 32'h0210_0000, "R7 fixed status");

    // R8 live interrupt bit unaffected by disable
    wr(6'd1, 32'h0000_0400, 4'b0011);
    @(negedge clk); irq_req = 1'b1;
    rd(6'd1, 32'h0218_0400, "R8 irq with disable");

    // R9 four combinations
    set_irq(1'b1, 1'b1, "R9 irq1 dis1");
    set_irq(1'b0, 1'b1, "R9 irq0 dis1");
    wr(6'd1, 32'h0, 4'b0011);
    set_irq(1'b0, 1'b1, "R9 irq0 dis0");
    set_irq(1'b1, 1'b0, "R9 irq1 dis0");
    set_irq(1'b0, 1'b1, "R9 irq drop");

    // R10 BARs
    wr(6'd4, 32'hFFFF_FFFF, 4'hF);
    rd(6'd4, 32'hFFFF_F000, "R10 bar0 size mask");
    wr(6'd5, 32'h0000_00FF, 4'b0001);
    rd(6'd5, 32'h0, "R10 bar1 low byte");
    wr(6'd5, 32'h0000_AB00, 4'b0010);
    rd(6'd5, 32'h0000_A000, "R10 bar1 byte1");
    wr(6'd6, 32'h1234_5678, 4'hF);
    rd(6'd6, 32'h1234_5000, "R10 bar2");
    rd(6'd4, 32'hFFFF_F000, "R10 bar0 untouched");

    // R11 capability
    rd(6'd13, 32'h0000_0040, "R11 cap pointer");
    rd(6'd16, {T_PMC, 16'h0}, "R11 pm cap");
    wr(6'd17, 32'h0000_0003, 4'hF);
    rd(6'd17, 32'h3, "R11 pm state");
    wr(6'd17, 32'hFFFF_FFFC, 4'hF);
    rd(6'd17, 32'h0, "R11 pm state clear");

    // R12 unimplemented
    wr(6'd7, 32'hFFFF_FFFF, 4'hF);
    rd(6'd7, 32'h0, "R12 unused bar");
    wr(6'd12, 32'hFFFF_FFFF, 4'hF);
    rd(6'd12, 32'h0, "R12 rom base");
    wr(6'd40, 32'hFFFF_FFFF, 4'hF);
    rd(6'd40, 32'h0, "R12 high index");

    // R13 read data holds without strobe
    rd(6'd1, 32'h0210_0000, "R13 read");
    @(negedge clk); evt_serr = 1'b1; @(negedge clk); evt_serr = 1'b0;
    @(negedge clk);
    chk("R13 hold", rd_data, 32'h0210_0000);
    wr(6'd1, 32'h4000_0000, 4'b1000);

    // R14 header bytes
    wr(6'd3, 32'hFFFF_FFFF, 4'hF);
    rd(6'd3, 32'h0000_FFFF, "R14 hdr bytes");
    wr(6'd15, 32'hFFFF_FFA5, 4'hF);
    rd(6'd15, {T_MAXL, T_MING, T_PIN, 8'hA5}, "R14 int line");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule